// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

This block models a single-clock synchronous SRAM with a four-beat burst address sequencer and a registered read path. On every rising clock edge the block samples the address, the control inputs and the write data. It then decides whether the edge starts a burst, continues one, holds one, deselects the device or does nothing. Reads come out through one output register. Writes go into 9-bit byte lanes.

Two address strobes can start an access. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write inputs sampled with it. Three chip selects decide whether a strobe is accepted or deselects the device. Two inputs are asynchronous. The output enable acts combinationally on the drive flag. The sleep input passes through a two-stage synchronizer before it shuts off the sampled inputs. The data bus is split into separate input and output ports, and a drive flag stands in for the tristate state.

Top module: `pburst_sram`

## Requirements
- R1: With all three selects active (`sel_n`=0, `sel_hi`=1, `sel_lo_n`=0), `strb_cpu_n`=0 starts a read at `addr_i`. Beat count 0 is loaded. No memory write takes place on that edge, whatever the write inputs are.
- R2: With all selects active, `strb_cpu_n`=1 and `strb_ctl_n`=0 start a burst at `addr_i`. The access is a write when the write decode of R6 selects at least one lane. Otherwise it is a read.
- R3: With `order_ilv`=1 sampled at burst start, the two low address bits of beat k are the start bits XOR k. The beats run in the order k = 0, 1, 2, 3, 0, and so on.
- R4: With `order_ilv`=0 sampled at burst start, the two low address bits of beat k are (start + k) mod 4. The upper address bits stay those of the start address for the whole burst.
- R5: When both strobes are inactive on an active burst, the edge is a continue or a suspend. `adv_n`=0 moves to the next beat. `adv_n`=1 repeats the current address. Either can read or write.
- R6: Write decode works as follows:
  - `wr_all_n`=0 writes all four lanes.
  - Otherwise `wr_byte_n`=0 writes each lane i whose `lane_n[i]`=0. Lane i is `din` bits 9i to 9i+8.
  - `wr_byte_n`=1, or `lane_n`=4'hF, makes the edge a read.
- R7: The data of a read whose address is sampled on edge N appears on `dout` after edge N+1, with `dout_en`=1 while `oe_n`=0.
- R8: `oe_n` acts on `dout_en` without waiting for a clock. `dout_en` can be 1 only in the cycle after a read edge. A write edge gives `dout_en`=0 in the following cycle.
- R9: Either of two cases deselects the device:
  - `sel_n`=1 with `strb_ctl_n`=0;
  - `sel_n`=0 with either secondary select inactive and either strobe low.

  A deselect ends the burst, so later continue edges access nothing. `dout_en` is 0 after the second edge that follows the deselect. With `sel_n`=1, `strb_cpu_n`=0 and `strb_ctl_n`=1, the edge is treated as a plain continue.
- R10: `dout_en` is 0 while `sleep`=1. After `sleep` rises, the first two edges are still sampled and later edges are ignored. After `sleep` falls, two more edges are ignored before sampling resumes. Sleep ends any burst.
- R11: After synchronous reset `dout_en`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | Word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | 1 = interleaved beat order, 0 = linear |
| sel_n | input | 1 | Primary chip select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel_lo_n | input | 1 | Secondary select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Output drive flag |

## Verification
Bursts are written and read back from both strobes in both beat orders. Each burst starts from a low-bit value other than zero, so a sequencer that ignores the start bits or mixes up XOR and add shows a wrong word. A fifth beat exposes a counter that fails to wrap. Lane masks that are sparse, empty or overridden tell the global write apart from the per-lane path, and they show whether a byte-write-high edge is decoded as a read. Deselects, an ignored processor strobe, an asynchronous enable toggle and a write attempted during sleep each separate an accepted edge from one that must leave memory and the drive flag untouched.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;

    localparam int BEATS_W = 2;

    // low address bits of a beat: interleaved uses xor, linear uses modulo add
    function automatic logic [BEATS_W-1:0] beat_low(
        input logic [BEATS_W-1:0] start,
        input logic [BEATS_W-1:0] beat,
        input logic               lin
    );
        return lin ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/pbs_sleep_sync.sv
`timescale 1ns/1ps
module pbs_sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_a,
    output logic gate
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) s_d.sh = {s_q.sh[STAGES-2:0], sleep_a};
        else            s_d.sh = sleep_a;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign gate = s_q.sh[STAGES-1];

endmodule

// File: rtl/pbs_seq.sv
`timescale 1ns/1ps
module pbs_seq
    import pbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_lin,
    input  logic          advance,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] nxt_addr
);
    typedef struct packed {
        logic [AW-1:0]      base;
        logic [BEATS_W-1:0] beat;
        logic               lin;
    } seq_t;

    seq_t q_d, q_q;
    logic [BEATS_W-1:0] beat_nx;

    assign beat_nx  = q_q.beat + 1'b1;
    assign cur_addr = {q_q.base[AW-1:BEATS_W], beat_low(q_q.base[BEATS_W-1:0], q_q.beat, q_q.lin)};
    assign nxt_addr = {q_q.base[AW-1:BEATS_W], beat_low(q_q.base[BEATS_W-1:0], beat_nx, q_q.lin)};

    always_comb begin
        q_d = q_q;
        if (load) begin
            q_d.base = load_addr;
            q_d.beat = '0;
            q_d.lin  = load_lin;
        end else if (advance) begin
            q_d.beat = beat_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    // R3: an advance without a reload steps the beat count by one
    a_r3_beat_steps: assert property (@(posedge clk) disable iff (rst)
        (advance && !load) |=> (q_q.beat == $past(q_q.beat) + 1'b1));

    // R5: a suspend keeps the burst position
    a_r5_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (!advance && !load) |=> $stable(cur_addr));

    // R4: upper bits fixed for the burst
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cur_addr[AW-1:BEATS_W] == $past(cur_addr[AW-1:BEATS_W])));

endmodule

// File: rtl/pbs_lane_mem.sv
`timescale 1ns/1ps
module pbs_lane_mem #(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
            rd_q <= store[raddr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram #(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_i,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             adv_n,
    input  logic             order_ilv,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);
    typedef struct packed {
        logic          act;
        logic          rd;
        logic [AW-1:0] rd_addr;
        logic          out_vld;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             gate;
    logic             sec_ok, sel_all;
    logic             desel, cpu_start, ctl_start, start, burst_cyc, advance;
    logic [LANES-1:0] wr_mask, lane_we;
    logic             wr_req, do_write, do_read;
    logic [AW-1:0]    cur_addr, nxt_addr, eff_addr;

    pbs_sleep_sync #(.STAGES(2)) u_sleep (
        .clk    (clk),
        .rst    (rst),
        .sleep_a(sleep),
        .gate   (gate)
    );

    // edge decode
    assign sec_ok    = sel_hi & ~sel_lo_n;
    assign sel_all   = ~sel_n & sec_ok;
    assign desel     = ~gate & ((sel_n & ~strb_ctl_n) |
                                (~sel_n & ~sec_ok & (~strb_cpu_n | ~strb_ctl_n)));
    assign cpu_start = ~gate & sel_all & ~strb_cpu_n;
    assign ctl_start = ~gate & sel_all & strb_cpu_n & ~strb_ctl_n;
    assign start     = cpu_start | ctl_start;
    assign burst_cyc = ~gate & st_q.act & strb_ctl_n & (strb_cpu_n | sel_n);
    assign advance   = burst_cyc & ~adv_n;

    // write decode: global write overrides the lane enables
    always_comb begin
        if (!wr_all_n)       wr_mask = '1;
        else if (!wr_byte_n) wr_mask = ~lane_n;
        else                 wr_mask = '0;
    end

    assign wr_req   = |wr_mask;
    assign do_write = (ctl_start | burst_cyc) & wr_req;
    assign do_read  = cpu_start | ((ctl_start | burst_cyc) & ~wr_req);
    assign lane_we  = do_write ? wr_mask : '0;

    pbs_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_addr(addr_i),
        .load_lin (~order_ilv),
        .advance  (advance),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    always_comb begin
        if (start)        eff_addr = addr_i;
        else if (advance) eff_addr = nxt_addr;
        else              eff_addr = cur_addr;
    end

    pbs_lane_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk  (clk),
        .we   (lane_we),
        .waddr(eff_addr),
        .wdata(din),
        .raddr(st_q.rd_addr),
        .rdata(dout)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rd      = 1'b0;
        st_d.out_vld = st_q.rd;
        if (gate) begin
            st_d.act = 1'b0;
        end else begin
            if (desel)      st_d.act = 1'b0;
            else if (start) st_d.act = 1'b1;
            if (do_read) begin
                st_d.rd      = 1'b1;
                st_d.rd_addr = eff_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_en = st_q.out_vld & ~oe_n & ~sleep;

    // R7: a read edge loads the output stage on the next edge
    a_r7_read_latency: assert property (@(posedge clk) disable iff (rst)
        st_q.rd |=> st_q.out_vld);

    // R9: outputs released by the second edge after a deselect
    a_r9_desel_release: assert property (@(posedge clk) disable iff (rst)
        desel |=> ##1 !st_q.out_vld);

    // R10: no lane written while the synchronized sleep is active
    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        gate |-> (lane_we == '0));

    // R1: processor strobe edge never reaches the memory write port
    a_r1_cpu_no_write: assert property (@(posedge clk) disable iff (rst)
        (!strb_cpu_n && !sel_n && sel_hi && !sel_lo_n) |-> (lane_we == '0));

    // R8: a write edge leaves the output stage empty afterwards
    a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (lane_we != '0) |=> ##1 !st_q.out_vld);

endmodule

// File: tb/test_pburst_sram.sv
`timescale 1ns/1ps
module test_pburst_sram;
    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_i;
    logic          strb_cpu_n, strb_ctl_n, adv_n, order_ilv;
    logic          sel_n, sel_hi, sel_lo_n;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    lane_n;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    pburst_sram i_pburst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .strb_cpu_n(strb_cpu_n),
        .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .order_ilv(order_ilv),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int total = 0;
    int bad   = 0;

    typedef struct {
        int            due;
        bit            en;
        logic [DW-1:0] data;
        string         req;
    } item_t;
    item_t sbq[$];

    logic [DW-1:0] ref_mem [1024];
    logic [AW-1:0] b_base;
    logic [1:0]    b_beat;
    bit            b_lin;

    task automatic chk(string r, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic push(bit en, logic [DW-1:0] d, string r);
        item_t it;
        it.due = cyc + 2; it.en = en; it.data = d; it.req = r;
        sbq.push_back(it);
    endtask

    // monitor: compare results as the design produces them
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            if (it.due != cyc) chk({it.req, " late"}, DW'(it.due), DW'(cyc));
            chk({it.req, " drive"}, DW'(dout_en), DW'(it.en));
            if (it.en) chk({it.req, " data"}, dout, it.data);
        end
    end

    function automatic logic [AW-1:0] b_addr();
        logic [1:0] lo;
        lo = b_lin ? (b_base[1:0] + b_beat) : (b_base[1:0] ^ b_beat);
        return {b_base[AW-1:2], lo};
    endfunction

    function automatic logic [3:0] lanes_of(bit gwn, bit bwen, logic [3:0] bwn);
        if (!gwn)  return 4'hF;
        if (!bwen) return ~bwn;
        return 4'h0;
    endfunction

    task automatic edge_t();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic base_in();
        sel_n = 0; sel_hi = 1; sel_lo_n = 0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_n = 4'hF;
        addr_i = '0; din = '0;
    endtask

    task automatic access(logic [AW-1:0] a, logic [3:0] lanes, logic [DW-1:0] d, string r);
        if (lanes != 0) begin
            for (int i = 0; i < 4; i++)
                if (lanes[i]) ref_mem[a][i*9 +: 9] = d[i*9 +: 9];
            push(0, '0, r);
        end else begin
            push(1, ref_mem[a], r);
        end
    endtask

    task automatic t_cpu_read(logic [AW-1:0] a, bit en, bit junk, string r);
        base_in();
        addr_i = a; strb_cpu_n = 0;
        if (junk) begin wr_all_n = 0; din = 36'hF_FFFF_FFFF; end
        b_base = a; b_beat = 0; b_lin = !order_ilv;
        push(en, ref_mem[a], r);
        edge_t();
    endtask

    task automatic t_ctl(logic [AW-1:0] a, bit gwn, bit bwen, logic [3:0] bwn,
                         logic [DW-1:0] d, string r);
        base_in();
        addr_i = a; strb_ctl_n = 0; wr_all_n = gwn; wr_byte_n = bwen; lane_n = bwn; din = d;
        b_base = a; b_beat = 0; b_lin = !order_ilv;
        access(a, lanes_of(gwn, bwen, bwn), d, r);
        edge_t();
    endtask

    task automatic t_next(bit advn, bit gwn, bit bwen, logic [3:0] bwn,
                          logic [DW-1:0] d, bit c1_off, string r);
        base_in();
        adv_n = advn; wr_all_n = gwn; wr_byte_n = bwen; lane_n = bwn; din = d;
        addr_i = 10'h3FF;
        if (c1_off) begin sel_n = 1; strb_cpu_n = 0; end
        if (!advn) b_beat = b_beat + 1;
        access(b_addr(), lanes_of(gwn, bwen, bwn), d, r);
        edge_t();
    endtask

    task automatic t_desel(bit secondary, string r);
        base_in();
        if (secondary) begin sel_hi = 0; strb_cpu_n = 0; end
        else begin sel_n = 1; strb_ctl_n = 0; end
        push(0, '0, r);
        edge_t();
    endtask

    initial begin
        #(8 * 20000);
        total++; bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        base_in();
        order_ilv = 1;
        repeat (3) edge_t();
        rst = 0;
        edge_t();
        chk("R11 reset drive", DW'(dout_en), '0);
        // R11: no burst after reset, so a continue edge reads nothing
        base_in(); adv_n = 0;
        edge_t(); edge_t();
        chk("R11 idle continue", DW'(dout_en), '0);

        // R2 R3: interleaved write burst via controller strobe, start 0x41
        order_ilv = 1;
        t_ctl(10'h041, 0, 1, 4'hF, 36'h1_1111_1111, "R2 write start");
        t_next(0, 0, 1, 4'hF, 36'h2_2222_2222, 0, "R3 write beat1");
        t_next(0, 0, 1, 4'hF, 36'h3_3333_3333, 0, "R3 write beat2");
        t_next(0, 0, 1, 4'hF, 36'h4_4444_4444, 0, "R3 write beat3");
        t_desel(0, "R9 desel");
        // R4: linear write burst, start 0x86
        order_ilv = 0;
        t_ctl(10'h086, 0, 1, 4'hF, 36'h5_5555_5555, "R4 write start");
        t_next(0, 0, 1, 4'hF, 36'h6_6666_6666, 0, "R4 write beat1");
        t_next(0, 0, 1, 4'hF, 36'h7_7777_7777, 0, "R4 write beat2");
        t_next(0, 0, 1, 4'hF, 36'h8_8888_8888, 0, "R4 write beat3");
        t_desel(0, "R9 desel");

        // R1 R3 R7: interleaved read from 0x42 by processor strobe
        order_ilv = 1;
        t_cpu_read(10'h042, 1, 0, "R1 read start");
        t_next(0, 1, 1, 4'hF, '0, 0, "R3 read beat1");
        t_next(0, 1, 1, 4'hF, '0, 0, "R3 read beat2");
        t_next(0, 1, 1, 4'hF, '0, 0, "R3 read beat3");
        t_desel(0, "R9 desel");

        // R4 R6: linear read via controller strobe (byte-write enable, no lanes)
        order_ilv = 0;
        t_ctl(10'h085, 1, 0, 4'hF, 36'h0_DEAD_0000, "R6 lanes off read");
        t_next(0, 1, 1, 4'hF, '0, 0, "R4 read beat1");
        t_next(0, 1, 1, 4'hF, '0, 0, "R4 read beat2");
        t_next(0, 1, 1, 4'hF, '0, 0, "R4 read beat3");
        t_next(0, 1, 1, 4'hF, '0, 0, "R4 wrap beat0");
        t_next(1, 1, 1, 4'hF, '0, 0, "R5 suspend read");
        t_desel(1, "R9 secondary desel");

        // R6: sparse lane write, then byte-write high reads back
        t_ctl(10'h041, 1, 0, 4'b1010, 36'hA_BCDE_F012, "R6 lanes 0 and 2");
        t_next(1, 1, 1, 4'h0, 36'h0_0000_0000, 0, "R6 bwe high read");
        t_next(1, 0, 1, 4'hF, 36'h9_8765_4321, 0, "R6 global override");
        t_next(1, 1, 1, 4'hF, '0, 0, "R6 read after global");
        t_desel(0, "R9 desel");

        // R1: processor strobe with write inputs active still reads
        t_cpu_read(10'h040, 1, 1, "R1 junk write ignored");
        t_cpu_read(10'h040, 1, 0, "R1 memory unchanged");

        // R8: asynchronous output enable
        t_cpu_read(10'h043, 1, 0, "R7 read");
        t_next(1, 1, 1, 4'hF, '0, 0, "R5 suspend");
        #1 oe_n = 1;
        #1 chk("R8 oe off", DW'(dout_en), '0);
        oe_n = 0;
        #1 chk("R8 oe on", DW'(dout_en), 1);
        t_desel(0, "R9 desel");

        // R9: ignored processor strobe with primary select off acts as continue
        order_ilv = 1;
        t_cpu_read(10'h084, 1, 0, "R9 start");
        t_next(0, 1, 1, 4'hF, '0, 1, "R9 cpu strobe ignored");
        t_desel(0, "R9 desel");
        base_in(); adv_n = 0;
        edge_t(); edge_t();
        chk("R9 continue after desel", DW'(dout_en), '0);

        // R10: sleep
        sleep = 1;
        t_cpu_read(10'h040, 0, 0, "R10 drive off in sleep");
        t_desel(0, "R10 second edge sampled");
        base_in(); addr_i = 10'h040; strb_ctl_n = 0; wr_all_n = 0; din = 36'h0_DEAD_BEEF;
        edge_t(); edge_t(); edge_t();
        chk("R10 sleep drive", DW'(dout_en), '0);
        base_in(); sel_n = 1; addr_i = 10'h040; strb_cpu_n = 0; wr_all_n = 0;
        sleep = 0;
        edge_t(); edge_t();
        t_cpu_read(10'h040, 1, 0, "R10 write ignored in sleep");
        t_desel(0, "R9 desel");

        base_in(); sel_n = 1;
        repeat (4) edge_t();
        chk("R7 queue drained", DW'(sbq.size()), '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule